// File: doc/BRIEF.md
# Paged Address Relocation and Abort Unit

This block turns a 16-bit virtual address into a 22-bit physical address for a processor with three privilege modes (kernel, supervisor, user) and optionally separate instruction and data spaces. The top three virtual address bits choose one of eight pages. The mode and the space choose the bank of page registers. Each page has a base register, which gives the physical base in 64-byte units, and a descriptor. The descriptor gives a length in 64-byte blocks, a growth direction, an access key and a cache-bypass hint. The block checks every access against the selected descriptor and flags an abort when the access is not allowed. It marks pages that have received a non-aborting write. It holds a status register that records the most recent page used and the cause of an abort. After an abort that register, and the register holding the current instruction address, stop updating until software clears the abort flags.

Translations flow as a valid/ready stream. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its result appears on the response port one cycle later. `req_ready` is high whenever the response slot is empty or `rsp_ready` is high. While `rsp_valid` is high and `rsp_ready` is low, the response stays unchanged and no new request is taken. Register access uses a plain port: a write takes effect on the clock edge, and a read is combinational on `reg_addr`.

Register map (`reg_addr`, 8 bits). When bit 7 is 0 the address selects a page register:
- bit 6 picks the descriptor (1) or the base (0);
- bits 5:4 give the mode (00 kernel, 01 supervisor, 11 user);
- bit 3 gives the space (1 data, 0 instruction);
- bits 2:0 give the page.

The three other registers sit at 0x80 (status), 0x81 (instruction address, read-only) and 0x82 (control). All other addresses read as 0.

Descriptor fields:
- bit 15: cache bypass;
- bits 14:8: length;
- bit 6: written;
- bit 3: direction (1 down);
- bits 2:1: key.

All other descriptor bits read as 0.

Status register fields:
- bit 15: non-resident abort;
- bit 14: length abort;
- bit 13: access abort;
- bits 6:5: mode;
- bit 4: space;
- bits 3:1: page;
- bit 0: relocation enable.

Control register fields:
- bit 4: 22-bit addressing;
- bits 2, 1, 0: separate data space for kernel, supervisor and user.

Top module: `mmu_reloc_top`

## Requirements
- R1: With relocation enabled and 22-bit addressing on, the physical address is (base << 6) + virtual bits 12:0, taken modulo 2^22.
- R2: With 22-bit addressing off, only base bits 11:0 are used, the sum is taken modulo 2^18, and physical bits 21:18 are 0.
- R3: With status bit 0 clear, the physical address is the virtual address zero-extended, no access aborts, and neither the status register nor any written bit changes.
- R4: Virtual bits 12:6 form a block number. With direction 0, a block above the length aborts. With direction 1, a block below the length aborts. Either abort sets status bit 14, and a block equal to the length passes.
- R5: Key 00 aborts as non-resident (status bit 15). Key 01 aborts writes as access violations (status bit 13) and passes reads. Keys 10 and 11 allow both reads and writes. Mode code 10 always aborts with status bit 13 only.
- R6: A write that does not abort sets the written bit of the selected descriptor. Reads and aborted writes leave it unchanged.
- R7: A software write to a base or a descriptor clears that page's written bit. A software write to the descriptor stores only bits 15:8, 3 and 2:1. A software write to the base stores all 16 bits.
- R8: While status bits 15:13 are all 0, each accepted access with relocation on loads bits 15:13 with its abort causes and bits 6:1 with its mode, space and page. While any of bits 15:13 is set, accesses leave the status register unchanged. A software write to the status register always lands, and stores only bits 15:13 and 6:0.
- R9: A pulse on `instr_start` loads `instr_pc` into the instruction address register unless status bits 15:13 hold a set flag.
- R10: A data access uses the data-space bank when the control bit for its mode is set (kernel bit 2, supervisor bit 1, user bit 0). Otherwise it uses the instruction-space bank.
- R11: `req_ready` is low only while a response is held with `rsp_ready` low. A held response does not change.
- R12: Reset clears the status, control and instruction address registers, every base and descriptor, and `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_va | input | 16 | Virtual address |
| req_mode | input | 2 | 00 kernel, 01 supervisor, 11 user, 10 illegal |
| req_data | input | 1 | Data reference (1) or instruction fetch (0) |
| req_write | input | 1 | Write access |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_pa | output | 22 | Physical address |
| rsp_abort | output | 1 | Access aborted |
| rsp_nocache | output | 1 | Cache bypass bit of the page used |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| instr_start | input | 1 | Start of instruction |
| instr_pc | input | 16 | Address of the starting instruction |

## Verification
The hardest situation to reach from the ports is a status register that is frozen while further aborting and non-aborting accesses and instruction starts keep arriving. This matters because the freeze must hold against every source of update except software. The bench gets there with directed length aborts, followed by more traffic and a pulse on `instr_start`, and it reads both registers back. Random traffic mixes software clears with descriptor writes carrying every key and direction, so freezes occur and are cleared repeatedly. Stalled responses are produced by holding `rsp_ready` low while a second request waits.

// File: rtl/mmu_pkg.sv
`timescale 1ns/1ps
package mmu_pkg;
  localparam int VA_W    = 16;
  localparam int REG_W   = 16;
  localparam int PG_W    = 3;
  localparam int BLK_LSB = 6;
  localparam int LEN_W   = VA_W - PG_W - BLK_LSB;
  localparam int PA_W    = REG_W + BLK_LSB;
  localparam int NARROW_BASE_W = 12;
  localparam int NARROW_PA_W   = NARROW_BASE_W + BLK_LSB;
  localparam int IDX_W   = 2 + 1 + PG_W;
  localparam int N_ENT   = 1 << IDX_W;
  localparam int ADDR_W  = 8;

  typedef enum logic [1:0] {
    MODE_KERN = 2'b00,
    MODE_SUPV = 2'b01,
    MODE_BAD  = 2'b10,
    MODE_USER = 2'b11
  } mode_e;

  typedef struct packed {
    logic nonres;
    logic length;
    logic access;
  } abort_t;

  localparam logic [REG_W-1:0]  DESC_WMASK = 16'hFF0E;
  localparam logic [REG_W-1:0]  STAT_WMASK = 16'hE07F;
  localparam logic [REG_W-1:0]  CTRL_WMASK = 16'h0017;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 8'h80;
  localparam logic [ADDR_W-1:0] ADDR_IPC   = 8'h81;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 8'h82;
endpackage

// File: rtl/mmu_page_file.sv
`timescale 1ns/1ps
module mmu_page_file
  import mmu_pkg::*;
#(
  parameter int ENTRIES = N_ENT,
  parameter int IW      = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic             sw_desc,
  input  logic [IW-1:0]    sw_idx,
  input  logic [REG_W-1:0] sw_wdata,
  input  logic             mark_w,
  input  logic [IW-1:0]    mark_idx,
  input  logic [IW-1:0]    lk_idx,
  output logic [REG_W-1:0] lk_base,
  output logic [REG_W-1:0] lk_desc,
  input  logic [IW-1:0]    rd_idx,
  input  logic             rd_desc,
  output logic [REG_W-1:0] rd_data
);
  logic [ENTRIES-1:0][REG_W-1:0] base_flat;
  logic [ENTRIES-1:0][REG_W-1:0] desc_flat;
  logic [ENTRIES-1:0]            w_flat;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             hit_sw;
    logic             hit_mk;
    logic [REG_W-1:0] base_r;
    logic [REG_W-1:0] desc_r;
    logic             w_r;

    assign hit_sw = sw_we  && (sw_idx   == IW'(g));
    assign hit_mk = mark_w && (mark_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_r <= '0;
        desc_r <= '0;
        w_r    <= 1'b0;
      end else if (hit_sw) begin
        if (sw_desc) desc_r <= sw_wdata & DESC_WMASK;
        else         base_r <= sw_wdata;
        w_r <= 1'b0;
      end else if (hit_mk) begin
        w_r <= 1'b1;
      end
    end

    assign base_flat[g] = base_r;
    assign desc_flat[g] = {desc_r[REG_W-1:7], w_r, desc_r[5:0]};
    assign w_flat[g]    = w_r;
  end

  assign lk_base = base_flat[lk_idx];
  assign lk_desc = desc_flat[lk_idx];
  assign rd_data = rd_desc ? desc_flat[rd_idx] : base_flat[rd_idx];

  // R7: any software write to a page leaves its written bit clear
  a_r7_sw_clears_w: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> !w_flat[$past(sw_idx)]);

  // R6: a marking write with no competing software write sets the bit
  a_r6_mark_sets_w: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_w && !(sw_we && sw_idx == mark_idx)) |=> w_flat[$past(mark_idx)]);
endmodule

// File: rtl/mmu_xlate.sv
`timescale 1ns/1ps
module mmu_xlate
  import mmu_pkg::*;
(
  input  logic [VA_W-1:0]  va,
  input  logic [1:0]       mode,
  input  logic             is_wr,
  input  logic             reloc_en,
  input  logic             wide_en,
  input  logic [REG_W-1:0] base,
  input  logic [REG_W-1:0] desc,
  output logic [PA_W-1:0]  pa,
  output abort_t           flags,
  output logic             nocache
);
  localparam int OFS_W = VA_W - PG_W;

  logic [LEN_W-1:0]       blk;
  logic [LEN_W-1:0]       plen;
  logic [1:0]             key;
  logic                   dir_down;
  logic                   len_bad;
  logic [PA_W-1:0]        sum_wide;
  logic [NARROW_PA_W-1:0] sum_narrow;
  logic                   unused_bits;

  assign blk      = va[OFS_W-1:BLK_LSB];
  assign plen     = desc[14:8];
  assign key      = desc[2:1];
  assign dir_down = desc[3];
  assign nocache  = desc[15];
  assign len_bad  = dir_down ? (blk < plen) : (blk > plen);

  assign sum_wide   = {base, {BLK_LSB{1'b0}}} + PA_W'(va[OFS_W-1:0]);
  assign sum_narrow = {base[NARROW_BASE_W-1:0], {BLK_LSB{1'b0}}}
                    + NARROW_PA_W'(va[OFS_W-1:0]);

  always_comb begin
    if (!reloc_en)    pa = PA_W'(va);
    else if (wide_en) pa = sum_wide;
    else              pa = PA_W'(sum_narrow);
  end

  always_comb begin
    flags = '0;
    if (reloc_en) begin
      if (mode == MODE_BAD) begin
        flags.access = 1'b1;
      end else begin
        flags.nonres = (key == 2'b00);
        flags.length = (key != 2'b00) && len_bad;
        flags.access = (key == 2'b01) && is_wr;
      end
    end
  end

  assign unused_bits = ^{desc[7:4], desc[0], va[VA_W-1:OFS_W]};
endmodule

// File: rtl/mmu_status.sv
`timescale 1ns/1ps
module mmu_status
  import mmu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_stat,
  input  logic             we_ctrl,
  input  logic [REG_W-1:0] wdata,
  input  logic             rec_en,
  input  abort_t           rec_flags,
  input  logic [1:0]       rec_mode,
  input  logic             rec_space,
  input  logic [PG_W-1:0]  rec_page,
  input  logic             instr_start,
  input  logic [VA_W-1:0]  instr_pc,
  output logic [REG_W-1:0] stat,
  output logic [VA_W-1:0]  ipc,
  output logic [REG_W-1:0] ctrl,
  output logic             frozen
);
  assign frozen = |stat[15:13];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
    end else if (we_stat) begin
      stat <= wdata & STAT_WMASK;
    end else if (rec_en && !frozen) begin
      stat[15:13] <= {rec_flags.nonres, rec_flags.length, rec_flags.access};
      stat[6:5]   <= rec_mode;
      stat[4]     <= rec_space;
      stat[3:1]   <= rec_page;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ipc <= '0;
    else if (instr_start && !frozen) ipc <= instr_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (we_ctrl) ctrl <= wdata & CTRL_WMASK;
  end

  // R8: a frozen status register moves only by software write
  a_r8_stat_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !we_stat) |=> $stable(stat));

  // R9: instruction address held while frozen
  a_r9_ipc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(ipc));
endmodule

// File: rtl/mmu_reloc_top.sv
`timescale 1ns/1ps
module mmu_reloc_top
  import mmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [1:0]        req_mode,
  input  logic              req_data,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_abort,
  output logic              rsp_nocache,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              instr_start,
  input  logic [VA_W-1:0]   instr_pc
);
  logic             fire;
  logic             ds_en;
  logic             space;
  logic [IDX_W-1:0] lk_idx;
  logic [REG_W-1:0] lk_base;
  logic [REG_W-1:0] lk_desc;
  logic [REG_W-1:0] pg_rdata;
  logic [REG_W-1:0] stat;
  logic [VA_W-1:0]  ipc;
  logic [REG_W-1:0] ctrl;
  logic             frozen;
  logic             reloc_en;
  logic             wide_en;
  logic [PA_W-1:0]  xl_pa;
  abort_t           xl_flags;
  logic             xl_nocache;
  logic             mark_w;
  logic             sw_pg_we;
  logic             we_stat;
  logic             we_ctrl;

  assign reloc_en = stat[0];
  assign wide_en  = ctrl[4];

  always_comb begin
    case (req_mode)
      MODE_KERN: ds_en = ctrl[2];
      MODE_SUPV: ds_en = ctrl[1];
      MODE_USER: ds_en = ctrl[0];
      default:   ds_en = 1'b0;
    endcase
  end

  assign space     = req_data && ds_en;
  assign lk_idx    = {req_mode, space, req_va[VA_W-1:VA_W-PG_W]};
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  assign sw_pg_we = reg_we && !reg_addr[ADDR_W-1];
  assign we_stat  = reg_we && (reg_addr == ADDR_STAT);
  assign we_ctrl  = reg_we && (reg_addr == ADDR_CTRL);
  assign mark_w   = fire && req_write && reloc_en && (xl_flags == '0);

  mmu_page_file #(.ENTRIES(N_ENT)) u_pages (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (sw_pg_we),
    .sw_desc  (reg_addr[IDX_W]),
    .sw_idx   (reg_addr[IDX_W-1:0]),
    .sw_wdata (reg_wdata),
    .mark_w   (mark_w),
    .mark_idx (lk_idx),
    .lk_idx   (lk_idx),
    .lk_base  (lk_base),
    .lk_desc  (lk_desc),
    .rd_idx   (reg_addr[IDX_W-1:0]),
    .rd_desc  (reg_addr[IDX_W]),
    .rd_data  (pg_rdata)
  );

  mmu_xlate u_xlate (
    .va       (req_va),
    .mode     (req_mode),
    .is_wr    (req_write),
    .reloc_en (reloc_en),
    .wide_en  (wide_en),
    .base     (lk_base),
    .desc     (lk_desc),
    .pa       (xl_pa),
    .flags    (xl_flags),
    .nocache  (xl_nocache)
  );

  mmu_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_stat     (we_stat),
    .we_ctrl     (we_ctrl),
    .wdata       (reg_wdata),
    .rec_en      (fire && reloc_en),
    .rec_flags   (xl_flags),
    .rec_mode    (req_mode),
    .rec_space   (space),
    .rec_page    (req_va[VA_W-1:VA_W-PG_W]),
    .instr_start (instr_start),
    .instr_pc    (instr_pc),
    .stat        (stat),
    .ipc         (ipc),
    .ctrl        (ctrl),
    .frozen      (frozen)
  );

  always_comb begin
    if (!reg_addr[ADDR_W-1])        reg_rdata = pg_rdata;
    else if (reg_addr == ADDR_STAT) reg_rdata = stat;
    else if (reg_addr == ADDR_IPC)  reg_rdata = ipc;
    else if (reg_addr == ADDR_CTRL) reg_rdata = ctrl;
    else                            reg_rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_pa      <= '0;
      rsp_abort   <= 1'b0;
      rsp_nocache <= 1'b0;
    end else if (fire) begin
      rsp_valid   <= 1'b1;
      rsp_pa      <= xl_pa;
      rsp_abort   <= |xl_flags;
      rsp_nocache <= xl_nocache;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R11: a stalled response is held unchanged
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_abort)));

  // R3: relocation off never aborts
  a_r3_off_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !reloc_en |-> (xl_flags == '0));

  // R2: narrow addressing keeps the top physical bits clear
  a_r2_narrow_pa: assert property (@(posedge clk) disable iff (!rst_n)
    (reloc_en && !wide_en) |-> (xl_pa[PA_W-1:NARROW_PA_W] == '0));
endmodule

// File: tb/tb_mmu_reloc_top.sv
`timescale 1ns/1ps
module tb_mmu_reloc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_data, req_write;
  logic [15:0] req_va;
  logic [1:0]  req_mode;
  logic        rsp_valid, rsp_ready, rsp_abort, rsp_nocache;
  logic [21:0] rsp_pa;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        instr_start;
  logic [15:0] instr_pc;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] m_base [64];
  logic [15:0] m_desc [64];
  logic [15:0] m_stat, m_ipc, m_ctrl;

  always #2.5 clk = ~clk;

  mmu_reloc_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_mode(req_mode), .req_data(req_data), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_abort(rsp_abort),
    .rsp_nocache(rsp_nocache), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .instr_start(instr_start), .instr_pc(instr_pc)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic m_space(input logic [1:0] mode, input logic data);
    logic en;
    case (mode)
      2'b00:   en = m_ctrl[2];
      2'b01:   en = m_ctrl[1];
      2'b11:   en = m_ctrl[0];
      default: en = 1'b0;
    endcase
    return data && en;
  endfunction

  function automatic logic [15:0] m_read(input logic [7:0] a);
    if (!a[7])          return a[6] ? m_desc[a[5:0]] : m_base[a[5:0]];
    else if (a == 8'h80) return m_stat;
    else if (a == 8'h81) return m_ipc;
    else if (a == 8'h82) return m_ctrl;
    return 16'h0;
  endfunction

  task automatic expect_xl(input logic [1:0] mode, input logic wr, input logic [15:0] va,
                           input logic [5:0] idx, output logic [21:0] pa, output logic [2:0] fl);
    logic [15:0] b, d;
    logic [6:0]  blk;
    logic [17:0] nsum;
    logic        lbad;
    b = m_base[idx];
    d = m_desc[idx];
    blk = va[12:6];
    fl = 3'b000;
    if (!m_stat[0]) begin
      pa = {6'b0, va};
    end else begin
      if (m_ctrl[4]) pa = {b, 6'b0} + {9'b0, va[12:0]};
      else begin
        nsum = {b[11:0], 6'b0} + {5'b0, va[12:0]};
        pa = {4'b0, nsum};
      end
      lbad = d[3] ? (blk < d[14:8]) : (blk > d[14:8]);
      if (mode == 2'b10) fl = 3'b001;
      else begin
        fl[2] = (d[2:1] == 2'b00);
        fl[1] = (d[2:1] != 2'b00) && lbad;
        fl[0] = (d[2:1] == 2'b01) && wr;
      end
    end
  endtask

  task automatic model_apply(input logic [1:0] mode, input logic sp, input logic wr,
                             input logic [15:0] va, input logic [5:0] idx, input logic [2:0] fl);
    if (m_stat[0]) begin
      if (m_stat[15:13] == 3'b000) begin
        m_stat[15:13] = fl;
        m_stat[6:1]   = {mode, sp, va[15:13]};
      end
      if (wr && fl == 3'b000) m_desc[idx][6] = 1'b1;
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (!a[7]) begin
      if (a[6]) m_desc[a[5:0]] = d & 16'hFF0E;
      else begin
        m_base[a[5:0]] = d;
        m_desc[a[5:0]][6] = 1'b0;
      end
    end else if (a == 8'h80) m_stat = d & 16'hE07F;
    else if (a == 8'h82)     m_ctrl = d & 16'h0017;
  endtask

  task automatic reg_chk(input logic [7:0] a, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == m_read(a), tag, {16'h0, reg_rdata}, {16'h0, m_read(a)});
  endtask

  task automatic access(input logic [1:0] mode, input logic data, input logic wr,
                        input logic [15:0] va, input string tag);
    logic        sp;
    logic [5:0]  idx;
    logic [21:0] epa;
    logic [2:0]  efl;
    @(negedge clk);
    sp = m_space(mode, data);
    idx = {mode, sp, va[15:13]};
    expect_xl(mode, wr, va, idx, epa, efl);
    req_valid = 1'b1; req_mode = mode; req_data = data; req_write = wr; req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, tag, {31'h0, rsp_valid}, 32'h1);
    chk(rsp_pa == epa, tag, {10'h0, rsp_pa}, {10'h0, epa});
    chk(rsp_abort == (efl != 3'b000), tag, {31'h0, rsp_abort}, {31'h0, (efl != 3'b000)});
    model_apply(mode, sp, wr, va, idx, efl);
  endtask

  task automatic instr(input logic [15:0] pc);
    @(negedge clk);
    instr_start = 1'b1; instr_pc = pc;
    @(negedge clk);
    instr_start = 1'b0;
    if (m_stat[15:13] == 3'b000) m_ipc = pc;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [21:0] pa1, pa2;
    logic [2:0]  f1, f2;
    for (int i = 0; i < 64; i++) begin
      m_base[i] = 16'h0;
      m_desc[i] = 16'h0;
    end
    m_stat = 0; m_ipc = 0; m_ctrl = 0;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; req_valid = 0; req_va = 0; req_mode = 0; req_data = 0; req_write = 0;
    rsp_ready = 1'b1; reg_we = 0; reg_addr = 0; reg_wdata = 0; instr_start = 0; instr_pc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    #1;
    chk(rsp_valid == 1'b0, "R12 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk(req_ready == 1'b1, "R11 ready idle", {31'h0, req_ready}, 32'h1);
    reg_chk(8'h80, "R12 status");
    reg_chk(8'h82, "R12 control");
    reg_chk(8'h81, "R12 ipc");
    reg_chk(8'h41, "R12 descriptor");

    // R3 relocation off
    access(2'b00, 1'b0, 1'b1, 16'hBEEF, "R3 pass-through");
    reg_chk(8'h80, "R3 status untouched");
    reg_chk(8'h45, "R3 no written bit");

    // R1 wide relocation
    reg_wr(8'h82, 16'h0010);
    reg_wr(8'h80, 16'h0001);
    reg_wr(8'h01, 16'h1234);
    reg_wr(8'h41, 16'h7F06);
    access(2'b00, 1'b0, 1'b0, 16'h2ABC, "R1 wide");
    reg_wr(8'h01, 16'hFFFF);
    access(2'b00, 1'b0, 1'b0, 16'h3FFF, "R1 wrap");

    // R2 narrow
    reg_wr(8'h82, 16'h0000);
    reg_wr(8'h01, 16'hF234);
    access(2'b00, 1'b0, 1'b0, 16'h2ABC, "R2 narrow");
    reg_wr(8'h01, 16'h0FFF);
    access(2'b00, 1'b0, 1'b0, 16'h3FC0, "R2 narrow wrap");
    reg_wr(8'h82, 16'h0010);

    // R4 length up
    reg_wr(8'h41, 16'h1006);
    access(2'b00, 1'b0, 1'b0, 16'h2400, "R4 up equal");
    access(2'b00, 1'b0, 1'b0, 16'h2440, "R4 up above");
    reg_chk(8'h80, "R4 length flag");
    // R8 / R9 frozen
    access(2'b00, 1'b0, 1'b0, 16'h2000, "R8 frozen access");
    reg_chk(8'h80, "R8 frozen status");
    instr(16'h1111);
    reg_chk(8'h81, "R9 frozen ipc");
    reg_wr(8'h80, 16'h0001);
    reg_chk(8'h80, "R8 software clear");
    instr(16'h2222);
    reg_chk(8'h81, "R9 ipc load");
    // R4 length down
    reg_wr(8'h41, 16'h100E);
    access(2'b00, 1'b0, 1'b0, 16'h23C0, "R4 down below");
    reg_wr(8'h80, 16'h0001);
    access(2'b00, 1'b0, 1'b0, 16'h2400, "R4 down equal");
    reg_chk(8'h80, "R8 record");

    // R5 keys and illegal mode
    reg_wr(8'h42, 16'h7F00);
    access(2'b00, 1'b0, 1'b0, 16'h4000, "R5 nonresident");
    reg_chk(8'h80, "R5 nonres flag");
    reg_wr(8'h80, 16'h0001);
    reg_wr(8'h42, 16'h7F02);
    access(2'b00, 1'b0, 1'b0, 16'h4000, "R5 read-only read");
    access(2'b00, 1'b0, 1'b1, 16'h4000, "R5 read-only write");
    reg_chk(8'h80, "R5 access flag");
    reg_chk(8'h42, "R6 aborted write no mark");
    reg_wr(8'h80, 16'h0001);
    access(2'b10, 1'b0, 1'b0, 16'h0000, "R5 illegal mode");
    reg_chk(8'h80, "R5 illegal flag");
    reg_wr(8'h80, 16'h0001);

    // R6 / R7 written bit
    reg_wr(8'h43, 16'h7F04);
    access(2'b00, 1'b0, 1'b0, 16'h6000, "R6 read");
    reg_chk(8'h43, "R6 read no mark");
    access(2'b00, 1'b0, 1'b1, 16'h6000, "R6 write");
    reg_chk(8'h43, "R6 written set");
    reg_wr(8'h03, 16'h0100);
    reg_chk(8'h43, "R7 base write clears");
    access(2'b00, 1'b0, 1'b1, 16'h6000, "R6 write again");
    reg_wr(8'h43, 16'hFFFF);
    reg_chk(8'h43, "R7 desc write masks");

    // R10 data space
    reg_wr(8'h09, 16'h0400);
    reg_wr(8'h49, 16'h7F06);
    reg_wr(8'h82, 16'h0014);
    access(2'b00, 1'b1, 1'b0, 16'h2100, "R10 kernel data space");
    reg_wr(8'h82, 16'h0010);
    access(2'b00, 1'b1, 1'b0, 16'h2100, "R10 shared space");
    reg_wr(8'h39, 16'h0777);
    reg_wr(8'h79, 16'h7F06);
    reg_wr(8'h82, 16'h0011);
    access(2'b11, 1'b1, 1'b0, 16'h2040, "R10 user data space");
    reg_chk(8'h80, "R10 space recorded");

    // R11 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    expect_xl(2'b00, 1'b0, 16'h2000, 6'h01, pa1, f1);
    req_valid = 1'b1; req_mode = 2'b00; req_data = 1'b0; req_write = 1'b0; req_va = 16'h2000;
    @(negedge clk);
    model_apply(2'b00, 1'b0, 1'b0, 16'h2000, 6'h01, f1);
    expect_xl(2'b00, 1'b0, 16'h2FC0, 6'h01, pa2, f2);
    req_va = 16'h2FC0;
    for (int k = 0; k < 3; k++) begin
      chk(req_ready == 1'b0, "R11 stalled ready", {31'h0, req_ready}, 32'h0);
      chk(rsp_pa == pa1 && rsp_valid, "R11 held response", {10'h0, rsp_pa}, {10'h0, pa1});
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    model_apply(2'b00, 1'b0, 1'b0, 16'h2FC0, 6'h01, f2);
    chk(rsp_valid && rsp_pa == pa2, "R11 second response", {10'h0, rsp_pa}, {10'h0, pa2});
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 drained", {31'h0, rsp_valid}, 32'h0);

    // random traffic
    for (int it = 0; it < 600; it++) begin
      int unsigned r;
      logic [15:0] d;
      logic [7:0]  a;
      r = $urandom % 12;
      case (r)
        0, 1: begin
          a = {1'b0, 7'($urandom)};
          d = 16'($urandom);
          if (a[6] && ($urandom % 3 != 0)) d[2:1] = 2'b11;
          reg_wr(a, d);
        end
        2: reg_wr(8'h82, 16'($urandom));
        3: reg_wr(8'h80, {9'h0, 6'($urandom), 1'($urandom % 8 != 0)});
        4: instr(16'($urandom));
        5: reg_chk(8'h80, "R8 random status");
        6: reg_chk({1'b0, 7'($urandom)}, "R7 random page reg");
        7: reg_chk(8'h81, "R9 random ipc");
        default: begin
          logic [1:0] md;
          md = 2'($urandom);
          access(md, 1'($urandom), 1'($urandom), 16'($urandom),
                 "R1 R4 R5 R6 R10 random access");
        end
      endcase
    end
    finish_run();
  end
endmodule